// File: doc/BRIEF.md
# Frame-Aligned Reset Release Controller

This block turns an asynchronous, active-low reset request into the internal reset of a switching device that runs on an 8 MHz clock. The internal reset drops as soon as the request goes low and does not wait for a clock edge. Its release passes through a two-stage synchronizer. The release is also held back so that it never takes effect in a narrow window that follows each input frame pulse: between 96 and 104 clock cycles after the pulse, which is 12 µs to 13 µs. A release that falls inside that window waits until the window has passed.

After the release, an access-ready flag stays low for 2000 clock cycles (250 µs). This gap gives downstream frame-format detection time to settle before any processor access. While the internal reset is active, or while the output-enable input is low, every serial output port is parked. Each port has its own strap input that picks its parked state: driven high or high-impedance.

There is no data stream through this block. All pins are plain control or status levels, so there is no valid/ready handshake and no back-pressure.

Top module: `frame_reset_ctrl`

## Requirements
- R1: When `rst_req_n` goes low, `int_rst_n` and `access_ready` go low at once, with no clock edge needed, and they stay low while `rst_req_n` is low.
- R2: After `rst_req_n` rises between two clock edges, `int_rst_n` rises on the third rising edge that follows, provided that edge is outside the forbidden window.
- R3: The frame phase is 0 in the cycle after the edge that samples `frame_pulse` high, and it rises by one per cycle. If the phase just before a would-be release edge is between 96 and 104 inclusive, the release is deferred to the first edge whose preceding phase is 105.
- R4: Once `int_rst_n` is high, it stays high for as long as `rst_req_n` stays high, whatever frame pulses arrive.
- R5: `access_ready` rises on exactly the 2000th rising edge after the edge that released `int_rst_n`, and it then stays high.
- R6: A new reset request clears `access_ready` immediately and restarts the full sequence. A countdown that was cut short never raises the flag.
- R7: While `int_rst_n` is low, port i is parked. If `park_hiz[i]` is 1, then `force_hiz[i]`=1 and `force_high[i]`=0. If `park_hiz[i]` is 0, then `force_high[i]`=1 and `force_hiz[i]`=0.
- R8: While `out_en` is low, the ports are parked exactly as in R7, whatever the reset state. The reset state itself does not change.
- R9: While `int_rst_n` and `out_en` are both high, every bit of `force_high` and `force_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz input clock |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| frame_pulse | input | 1 | Input frame pulse, one cycle high per frame |
| out_en | input | 1 | Output enable; low parks all ports |
| park_hiz | input | NUM_PORTS | Per-port strap: 1 parks high-impedance, 0 parks driven high |
| int_rst_n | output | 1 | Internal reset, active low |
| access_ready | output | 1 | High once processor access is allowed |
| force_high | output | NUM_PORTS | Per-port command to drive the output high |
| force_hiz | output | NUM_PORTS | Per-port command to tri-state the output |

## Verification
The internal reset is due on the third rising edge after the request rises, or on the edge that ends a deferral. The bench derives that edge from the frame phase and pushes it into a scoreboard queue, and a monitor pops it when it sees the release. The access-ready flag is due 2000 edges after the release edge, so the bench samples it one edge earlier, where it must still be low, and on the due edge, where it must be high. The park outputs follow their inputs in the same cycle. All samples are taken on falling clock edges. Assertion of the reset is checked half a nanosecond after the request falls, well before any clock edge.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic {
    PARK_HIGH = 1'b0,
    PARK_HIZ  = 1'b1
  } park_e;

  function automatic int cnt_w(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/frr_sync.sv
module frr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/frr_phase.sv
module frr_phase #(
  parameter int WIN_LO = 96,
  parameter int WIN_HI = 104
) (
  input  logic clk,
  input  logic pulse,
  output logic in_win
);
  localparam int W   = frr_pkg::cnt_w(WIN_HI + 1);
  localparam logic [W-1:0] CAP = W'(WIN_HI + 1);
  localparam logic [W-1:0] LO  = W'(WIN_LO);
  localparam logic [W-1:0] HI  = W'(WIN_HI);

  // Phase timing is kept across reset on purpose: it decides the release.
  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (pulse)             phase <= '0;
    else if (phase != CAP) phase <= phase + 1'b1;
  end

  assign in_win = (phase >= LO) && (phase <= HI);
endmodule

// File: rtl/frr_ready.sv
module frr_ready #(
  parameter int DELAY = 2000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  output logic ready
);
  localparam int W = frr_pkg::cnt_w(DELAY);
  localparam logic [W-1:0] LAST = W'(DELAY - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (run && !ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_reset_ctrl.sv
module frame_reset_ctrl #(
  parameter int NUM_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LO      = 96,
  parameter int WIN_HI      = 104,
  parameter int READY_DELAY = 2000
) (
  input  logic                 clk,
  input  logic                 rst_req_n,
  input  logic                 frame_pulse,
  input  logic                 out_en,
  input  logic [NUM_PORTS-1:0] park_hiz,
  output logic                 int_rst_n,
  output logic                 access_ready,
  output logic [NUM_PORTS-1:0] force_high,
  output logic [NUM_PORTS-1:0] force_hiz
);
  import frr_pkg::*;

  logic req_sync;
  logic in_win;
  logic released;
  logic park;

  frr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_req_n),
    .q      (req_sync)
  );

  frr_phase #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_phase (
    .clk    (clk),
    .pulse  (frame_pulse),
    .in_win (in_win)
  );

  always_ff @(posedge clk or negedge rst_req_n) begin
    if (!rst_req_n)                          released <= 1'b0;
    else if (!released && req_sync && !in_win) released <= 1'b1;
  end

  assign int_rst_n = released;

  frr_ready #(.DELAY(READY_DELAY)) u_ready (
    .clk    (clk),
    .arst_n (rst_req_n),
    .run    (released),
    .ready  (access_ready)
  );

  assign park = !released || !out_en;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      park_e mode;
      assign mode          = park_e'(park_hiz[i]);
      assign force_hiz[i]  = park && (mode == PARK_HIZ);
      assign force_high[i] = park && (mode == PARK_HIGH);
    end
  endgenerate
endmodule

// File: rtl/frr_checks.sv
module frr_checks #(
  parameter int NUM_PORTS   = 2,
  parameter int READY_DELAY = 2000
) (
  input logic                 clk,
  input logic                 rst_req_n,
  input logic                 out_en,
  input logic [NUM_PORTS-1:0] park_hiz,
  input logic                 int_rst_n,
  input logic                 access_ready,
  input logic [NUM_PORTS-1:0] force_high,
  input logic [NUM_PORTS-1:0] force_hiz,
  input logic                 in_win
);
  localparam int CW = frr_pkg::cnt_w(READY_DELAY + 1);
  localparam logic [CW-1:0] CAP = CW'(READY_DELAY + 1);

  logic [CW-1:0] since_rel;

  always_ff @(posedge clk or negedge rst_req_n) begin
    if (!rst_req_n)        since_rel <= '0;
    else if (!int_rst_n)   since_rel <= '0;
    else if (since_rel != CAP) since_rel <= since_rel + 1'b1;
  end

  a_r1_low_in_reset: assert property (@(posedge clk)
    !rst_req_n |-> (!int_rst_n && !access_ready));

  a_r2_sync_depth: assert property (@(posedge clk) disable iff (!rst_req_n)
    $rose(int_rst_n) |-> ($past(rst_req_n) && $past(rst_req_n, 2)));

  a_r3_not_in_window: assert property (@(posedge clk) disable iff (!rst_req_n)
    $rose(int_rst_n) |-> !$past(in_win));

  a_r4_stays_released: assert property (@(posedge clk) disable iff (!rst_req_n)
    int_rst_n |=> int_rst_n);

  a_r5_ready_timing: assert property (@(posedge clk) disable iff (!rst_req_n)
    $rose(access_ready) |-> (since_rel == CW'(READY_DELAY)));

  a_r6_ready_needs_release: assert property (@(posedge clk)
    !int_rst_n |-> !access_ready);

  a_r7_park_in_reset: assert property (@(posedge clk)
    !int_rst_n |-> ((force_hiz == park_hiz) && (force_high == ~park_hiz)));

  a_r8_park_when_disabled: assert property (@(posedge clk)
    !out_en |-> ((force_hiz == park_hiz) && (force_high == ~park_hiz)));

  a_r9_free_when_running: assert property (@(posedge clk)
    (int_rst_n && out_en) |-> ((force_hiz == '0) && (force_high == '0)));
endmodule

bind frame_reset_ctrl frr_checks #(
  .NUM_PORTS   (NUM_PORTS),
  .READY_DELAY (READY_DELAY)
) u_chk (
  .clk          (clk),
  .rst_req_n    (rst_req_n),
  .out_en       (out_en),
  .park_hiz     (park_hiz),
  .int_rst_n    (int_rst_n),
  .access_ready (access_ready),
  .force_high   (force_high),
  .force_hiz    (force_hiz),
  .in_win       (in_win)
);

// File: tb/frame_reset_ctrl_test.sv
`timescale 1ns/1ps
module frame_reset_ctrl_test;
  localparam int FRAME = 200;
  localparam int LO    = 96;
  localparam int HI    = 104;
  localparam int DLY   = 2000;

  logic       clk = 1'b0;
  logic       rst_req_n = 1'b0;
  logic       frame_pulse = 1'b0;
  logic       out_en = 1'b1;
  logic [1:0] park_hiz = 2'b10;
  logic       int_rst_n;
  logic       access_ready;
  logic [1:0] force_high;
  logic [1:0] force_hiz;

  always #2 clk = ~clk;

  frame_reset_ctrl uut (
    .clk          (clk),
    .rst_req_n    (rst_req_n),
    .frame_pulse  (frame_pulse),
    .out_en       (out_en),
    .park_hiz     (park_hiz),
    .int_rst_n    (int_rst_n),
    .access_ready (access_ready),
    .force_high   (force_high),
    .force_hiz    (force_hiz)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Pulse sampled on every edge whose number is a multiple of FRAME.
  initial forever begin
    @(negedge clk);
    frame_pulse = ((cyc % FRAME) == FRAME - 1);
  end

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int due_edge(input int c);
    int e;
    int ph;
    e  = c + 3;
    ph = (e - 1) % FRAME;
    if (ph >= LO && ph <= HI) e = e + (HI + 1 - ph);
    return e;
  endfunction

  // Monitor: pops the scoreboard on every observed release.
  bit prev = 1'b0;
  initial forever begin
    @(negedge clk);
    if (int_rst_n && !prev) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected release", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R2/R3 release edge", cyc, e);
      end
    end else if (!int_rst_n && prev && rst_req_n) begin
      check(1'b0, "R4 spurious reset", 0, 1);
    end
    prev = int_rst_n;
  end

  task automatic pull_reset();
    @(posedge clk);
    #1 rst_req_n = 1'b0;
    #0.5;
    check(!int_rst_n, "R1 async reset", int'(int_rst_n), 0);
    check(!access_ready, "R6 ready cleared", int'(access_ready), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic release_at(input int ph, output int e);
    @(negedge clk);
    while (!(cyc >= FRAME && ((cyc + 2) % FRAME) == ph)) @(negedge clk);
    rst_req_n = 1'b1;
    e = due_edge(cyc);
    exp_q.push_back(e);
    while (cyc < e - 1) @(negedge clk);
    check(!int_rst_n, "R3 held before due edge", int'(int_rst_n), 0);
    while (cyc < e + 2) @(negedge clk);
    check(exp_q.size() == 0 && int_rst_n, "R2 released", int'(int_rst_n), 1);
  endtask

  task automatic expect_ready(input int e);
    while (cyc < e + DLY - 1) @(negedge clk);
    check(!access_ready, "R5 early", int'(access_ready), 0);
    @(negedge clk);
    check(access_ready, "R5 on time", int'(access_ready), 1);
  endtask

  initial begin
    int e;
    int e1;
    int phs[5] = '{95, 96, 100, 104, 105};
    repeat (5) @(negedge clk);
    check(!int_rst_n, "R1 reset state", int'(int_rst_n), 0);
    check(!access_ready, "R6 reset state", int'(access_ready), 0);
    check(force_hiz == 2'b10, "R7 hiz park", int'(force_hiz), 2);
    check(force_high == 2'b01, "R7 high park", int'(force_high), 1);

    release_at(50, e);
    check(force_hiz == 2'b00 && force_high == 2'b00, "R9 free",
          int'({force_hiz, force_high}), 0);
    expect_ready(e);
    @(negedge clk);
    check(access_ready, "R5 stays high", int'(access_ready), 1);

    while ((cyc % FRAME) != 100) @(negedge clk);
    check(int_rst_n, "R4 held through window", int'(int_rst_n), 1);

    out_en = 1'b0;
    @(negedge clk);
    check(force_hiz == 2'b10 && force_high == 2'b01, "R8 disable park",
          int'({force_hiz, force_high}), 9);
    check(int_rst_n && access_ready, "R8 state kept",
          int'({int_rst_n, access_ready}), 3);
    park_hiz = 2'b01;
    @(negedge clk);
    check(force_hiz == 2'b01 && force_high == 2'b10, "R8 straps swapped",
          int'({force_hiz, force_high}), 6);
    out_en = 1'b1;
    park_hiz = 2'b10;

    foreach (phs[k]) begin
      pull_reset();
      release_at(phs[k], e);
    end

    pull_reset();
    release_at(20, e1);
    repeat (500) @(negedge clk);
    pull_reset();
    release_at(30, e);
    while (cyc < e1 + DLY) @(negedge clk);
    check(!access_ready, "R6 restarted countdown", int'(access_ready), 0);
    expect_ready(e);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule